// File: doc/BRIEF.md
# Per-Thread Issue-Queue Entry Partitioner

This block keeps the occupancy bookkeeping for an issue queue that several hardware threads share. It does not hold any instructions. It holds one occupancy counter per thread, one per-thread entry limit, and a global free-entry count. From these it tells each thread how many more entries it may take. It also tells the front end whether the queue as a whole is full.

Three sharing policies are available:

- **Shared:** any thread may fill the whole queue.
- **Equal split:** the queue is divided evenly between threads.
- **Percentage cap:** each thread may hold at most a programmed fraction of the queue.

The policy and the percentage are captured while reset is asserted. Whenever the set of active threads changes, the limits of the active threads are recalculated under the captured policy.

Each cycle, every thread may raise an allocate pulse, a release pulse, or both. A release covers an entry that has issued (non-memory work), completed (memory work) or been squashed. An allocate that finds no room in its thread's share, or no room left in the queue, is refused, and the refusal is flagged in the same cycle. When allocates compete for the last free entries, the lower thread index wins.

Top module: `iq_share_ctrl`

## Requirements
- R1: During reset, all occupancies clear and the global free count loads the total entry count. Every limit loads from the policy code and percentage present during reset. The codes are:
  - 0 or 3: shared, limit = total.
  - 1: equal split, limit = total / thread count, integer division.
  - 2: percentage cap, limit = floor(min(pct,100) × total / 100).

  Later changes to the policy and percentage inputs have no effect until the next reset.
- R2: Under the shared policy, every limit stays at the total entry count, including after active-mask changes.
- R3: Under equal split, a change of the active mask to a nonzero value sets each active thread's limit, at the next clock edge, to total / (number of set mask bits). Limits of inactive threads are kept.
- R4: Under the percentage cap, a change of the active mask to exactly one set bit raises that thread's limit to the total. Any other mask change leaves all limits unchanged.
- R5: The per-thread free count equals the limit minus the occupancy, clamped at zero when the occupancy is above the limit. The per-thread full flag is set when that count is zero.
- R6: An accepted allocate raises that thread's occupancy by one and lowers the global free count by one at the next clock edge.
- R7: An allocate without a release on the same thread is refused when the thread is full. The thread's error bit is set combinationally in that cycle, and no count changes.
- R8: The global full flag is set when the global free count is zero. Competing allocates are granted in ascending thread index while free entries remain. Each allocate left without an entry is refused with its error bit set.
- R9: Allocate and release on the same thread in the same cycle cancel. No count changes, and no error is raised, even when the thread or the queue is full.
- R10: A release on a thread whose occupancy is zero is ignored.
- R11: The global free count always equals the total entry count minus the sum of the thread occupancies.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; policy and percentage are captured while high |
| share_pol | input | 2 | Sharing policy code (0 shared, 1 equal split, 2 percentage cap, 3 shared) |
| cap_pct | input | 7 | Percentage used by the percentage-cap policy (values above 100 act as 100) |
| act_mask | input | NUM_THREADS | Active-thread mask; a change to a nonzero value triggers limit recalculation |
| alloc_req | input | NUM_THREADS | Per-thread allocate pulse |
| release_req | input | NUM_THREADS | Per-thread release pulse (issue, completion or squash) |
| thr_free | output | NUM_THREADS×CW | Per-thread free count, CW = clog2(NUM_ENTRIES+1) bits each |
| thr_full | output | NUM_THREADS | Per-thread full flag |
| glob_free | output | CW | Global free-entry count |
| glob_full | output | 1 | Global full flag |
| alloc_err | output | NUM_THREADS | Per-thread allocate-refused flag, same cycle as the request |

## Verification
The hardest state to reach from the ports is a thread whose occupancy sits above its limit. It only arises when a mask change shrinks the equal-split share of a thread that already filled a larger share. The stimulus gets there by first narrowing the active mask so that one thread's share grows, then filling that thread past the later share, and then widening the mask again. The clamped free count and the drain back below the limit are then checked. The second hard state is contention for the last global entries: a vector sequence fills the queue exactly, frees two entries, and then has all threads allocate together, so that the index-ordered grant is exposed.

// File: rtl/iqs_pkg.sv
package iqs_pkg;

    typedef enum logic [1:0] {
        POL_SHARED = 2'd0,
        POL_SPLIT  = 2'd1,
        POL_PCT    = 2'd2,
        POL_RSVD   = 2'd3
    } share_pol_e;

    localparam int PCT_W   = 7;
    localparam int PCT_MAX = 100;

    // Per-thread action chosen by the grant chain
    typedef struct packed {
        logic inc;
        logic dec;
        logic err;
    } thr_act_t;

    function automatic int pct_share(input int total, input logic [PCT_W-1:0] pct);
        int p;
        p = (int'(pct) > PCT_MAX) ? PCT_MAX : int'(pct);
        return (p * total) / PCT_MAX;
    endfunction

    function automatic int split_share(input int total, input int cnt);
        return (cnt == 0) ? total : total / cnt;
    endfunction

    function automatic int base_limit(input share_pol_e pol, input int total,
                                      input int nthr, input logic [PCT_W-1:0] pct);
        case (pol)
            POL_SPLIT: return split_share(total, nthr);
            POL_PCT:   return pct_share(total, pct);
            default:   return total;
        endcase
    endfunction

endpackage

// File: rtl/iqs_limit_table.sv
module iqs_limit_table
    import iqs_pkg::*;
#(
    parameter int NT = 4,
    parameter int NE = 16,
    parameter int CW = $clog2(NE + 1)
) (
    input  logic                    clk,
    input  logic                    rst,
    input  share_pol_e              pol,
    input  logic [PCT_W-1:0]        pct,
    input  logic [NT-1:0]           act_mask,
    output logic [NT-1:0][CW-1:0]   limit
);
    share_pol_e     pol_q;
    logic [NT-1:0]  mask_q;
    logic           mask_chg;
    int             act_cnt;

    always_comb begin
        act_cnt  = $countones(act_mask);
        mask_chg = (act_mask != mask_q) && (act_mask != '0);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pol_q  <= pol;
            mask_q <= act_mask;
            for (int t = 0; t < NT; t++)
                limit[t] <= CW'(base_limit(pol, NE, NT, pct));
        end else begin
            mask_q <= act_mask;
            if (mask_chg) begin
                for (int t = 0; t < NT; t++) begin
                    if (act_mask[t]) begin
                        case (pol_q)
                            POL_SPLIT: limit[t] <= CW'(split_share(NE, act_cnt));
                            POL_PCT:   if (act_cnt == 1) limit[t] <= CW'(NE);
                            default:   limit[t] <= limit[t];
                        endcase
                    end
                end
            end
        end
    end

    for (genvar g = 0; g < NT; g++) begin : g_chk
        // R2: shared policy pins every limit at the total
        a_r2_shared_fixed: assert property (@(posedge clk) disable iff (rst)
            (pol_q == POL_SHARED || pol_q == POL_RSVD) |-> (limit[g] == CW'(NE)));
        // R3: inactive threads keep their limit across a recalculation
        a_r3_inactive_kept: assert property (@(posedge clk) disable iff (rst)
            !act_mask[g] |=> (limit[g] == $past(limit[g])));
        // R4: percentage cap only moves a limit when one thread is active
        a_r4_pct_single: assert property (@(posedge clk) disable iff (rst)
            (pol_q == POL_PCT && act_cnt != 1) |=> $stable(limit[g]));
    end

endmodule

// File: rtl/iqs_thread_occ.sv
module iqs_thread_occ #(
    parameter int CW = 5
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          inc,
    input  logic          dec,
    input  logic [CW-1:0] limit,
    output logic [CW-1:0] occ,
    output logic [CW-1:0] free_cnt,
    output logic          full
);
    always_ff @(posedge clk) begin
        if (rst)      occ <= '0;
        else if (inc) occ <= occ + 1'b1;
        else if (dec) occ <= occ - 1'b1;
    end

    always_comb begin
        free_cnt = (occ >= limit) ? '0 : limit - occ;
        full     = (free_cnt == '0);
    end

    // R6: an accepted allocate adds exactly one entry
    a_r6_inc_step: assert property (@(posedge clk) disable iff (rst)
        inc |=> (occ == $past(occ) + 1'b1));
    // R7: the grant chain never hands an entry to a full thread
    a_r7_no_grant_full: assert property (@(posedge clk) disable iff (rst)
        inc |-> !full);
    // R10: an empty thread never wraps below zero
    a_r10_floor: assert property (@(posedge clk) disable iff (rst)
        (occ == '0 && !inc) |=> (occ == '0));

endmodule

// File: rtl/iqs_grant_chain.sv
module iqs_grant_chain
    import iqs_pkg::*;
#(
    parameter int NT = 4,
    parameter int CW = 5
) (
    input  logic [NT-1:0]   alloc,
    input  logic [NT-1:0]   rel,
    input  logic [NT-1:0]   thr_full,
    input  logic [NT-1:0]   occ_zero,
    input  logic [CW-1:0]   glob_free,
    output thr_act_t [NT-1:0] act
);
    logic [CW-1:0] budget;

    always_comb begin
        budget = glob_free;
        for (int t = 0; t < NT; t++) begin
            act[t] = '0;
            if (alloc[t] && rel[t]) begin
                act[t] = '0;
            end else if (alloc[t]) begin
                if (!thr_full[t] && budget != '0) begin
                    act[t].inc = 1'b1;
                    budget     = budget - 1'b1;
                end else begin
                    act[t].err = 1'b1;
                end
            end else if (rel[t] && !occ_zero[t]) begin
                act[t].dec = 1'b1;
            end
        end
    end

endmodule

// File: rtl/iq_share_ctrl.sv
module iq_share_ctrl
    import iqs_pkg::*;
#(
    parameter int NUM_ENTRIES = 16,
    parameter int NUM_THREADS = 4,
    localparam int CW = $clog2(NUM_ENTRIES + 1)
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic [1:0]                        share_pol,
    input  logic [PCT_W-1:0]                  cap_pct,
    input  logic [NUM_THREADS-1:0]            act_mask,
    input  logic [NUM_THREADS-1:0]            alloc_req,
    input  logic [NUM_THREADS-1:0]            release_req,
    output logic [NUM_THREADS-1:0][CW-1:0]    thr_free,
    output logic [NUM_THREADS-1:0]            thr_full,
    output logic [CW-1:0]                     glob_free,
    output logic                              glob_full,
    output logic [NUM_THREADS-1:0]            alloc_err
);
    localparam int NT = NUM_THREADS;

    logic [NT-1:0][CW-1:0] limit;
    logic [NT-1:0][CW-1:0] occ;
    logic [NT-1:0]         occ_zero;
    logic [NT-1:0]         inc;
    logic [NT-1:0]         dec;
    thr_act_t [NT-1:0]     act;
    int                    occ_sum;

    iqs_limit_table #(.NT(NT), .NE(NUM_ENTRIES), .CW(CW)) u_limits (
        .clk      (clk),
        .rst      (rst),
        .pol      (share_pol_e'(share_pol)),
        .pct      (cap_pct),
        .act_mask (act_mask),
        .limit    (limit)
    );

    iqs_grant_chain #(.NT(NT), .CW(CW)) u_grant (
        .alloc     (alloc_req),
        .rel       (release_req),
        .thr_full  (thr_full),
        .occ_zero  (occ_zero),
        .glob_free (glob_free),
        .act       (act)
    );

    for (genvar t = 0; t < NT; t++) begin : g_thr
        iqs_thread_occ #(.CW(CW)) u_occ (
            .clk      (clk),
            .rst      (rst),
            .inc      (inc[t]),
            .dec      (dec[t]),
            .limit    (limit[t]),
            .occ      (occ[t]),
            .free_cnt (thr_free[t]),
            .full     (thr_full[t])
        );
    end

    always_comb begin
        occ_sum = 0;
        for (int t = 0; t < NT; t++) begin
            inc[t]       = act[t].inc;
            dec[t]       = act[t].dec;
            alloc_err[t] = act[t].err;
            occ_zero[t]  = (occ[t] == '0);
            occ_sum      = occ_sum + int'(occ[t]);
        end
        glob_full = (glob_free == '0);
    end

    always_ff @(posedge clk) begin
        if (rst) glob_free <= CW'(NUM_ENTRIES);
        else     glob_free <= glob_free - CW'($countones(inc)) + CW'($countones(dec));
    end

    // R11: the global count tracks the per-thread counters
    a_r11_conserve: assert property (@(posedge clk) disable iff (rst)
        int'(glob_free) == NUM_ENTRIES - occ_sum);
    // R8: never grant more entries than remain free
    a_r8_budget: assert property (@(posedge clk) disable iff (rst)
        $countones(inc) <= int'(glob_free));
    // R8: a full queue grants nothing
    a_r8_full_blocks: assert property (@(posedge clk) disable iff (rst)
        glob_full |-> (inc == '0));

    for (genvar t = 0; t < NT; t++) begin : g_chk
        // R7: a lone allocate to a full thread is flagged
        a_r7_reject: assert property (@(posedge clk) disable iff (rst)
            (alloc_req[t] && !release_req[t] && thr_full[t]) |-> alloc_err[t]);
        // R9: paired allocate and release leave the count alone
        a_r9_cancel: assert property (@(posedge clk) disable iff (rst)
            (alloc_req[t] && release_req[t]) |=> (occ[t] == $past(occ[t])));
    end

endmodule

// File: tb/iq_share_ctrl_bench.sv
module iq_share_ctrl_bench;
    localparam int P  = 10;
    localparam int NE = 16;
    localparam int NT = 4;
    localparam int CW = 5;

    typedef struct packed {
        logic [3:0] alloc;
        logic [3:0] rel;
        logic [3:0] err;
        logic [4:0] gfree;
        logic [4:0] t0free;
    } vec_t;

    // Shared policy, all threads active, limit 16 each
    localparam vec_t VECS [12] = '{
        '{4'b1111, 4'b0000, 4'b0000, 5'd12, 5'd15},
        '{4'b0001, 4'b0000, 4'b0000, 5'd11, 5'd14},
        '{4'b0001, 4'b0001, 4'b0000, 5'd11, 5'd14},
        '{4'b0000, 4'b0010, 4'b0000, 5'd12, 5'd14},
        '{4'b0000, 4'b0010, 4'b0000, 5'd12, 5'd14},
        '{4'b1111, 4'b0000, 4'b0000, 5'd8,  5'd13},
        '{4'b1111, 4'b0000, 4'b0000, 5'd4,  5'd12},
        '{4'b1111, 4'b0000, 4'b0000, 5'd0,  5'd11},
        '{4'b0011, 4'b0000, 4'b0011, 5'd0,  5'd11},
        '{4'b0100, 4'b0100, 4'b0000, 5'd0,  5'd11},
        '{4'b0000, 4'b0011, 4'b0000, 5'd2,  5'd12},
        '{4'b1111, 4'b0000, 4'b1100, 5'd0,  5'd11}
    };

    logic                  clk = 1'b0;
    logic                  rst = 1'b1;
    logic [1:0]            share_pol = 2'd0;
    logic [6:0]            cap_pct = 7'd0;
    logic [NT-1:0]         act_mask = 4'b1111;
    logic [NT-1:0]         alloc_req = '0;
    logic [NT-1:0]         release_req = '0;
    logic [NT-1:0][CW-1:0] thr_free;
    logic [NT-1:0]         thr_full;
    logic [CW-1:0]         glob_free;
    logic                  glob_full;
    logic [NT-1:0]         alloc_err;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    iq_share_ctrl #(.NUM_ENTRIES(NE), .NUM_THREADS(NT)) u_iq_share_ctrl (
        .clk, .rst, .share_pol, .cap_pct, .act_mask, .alloc_req, .release_req,
        .thr_free, .thr_full, .glob_free, .glob_full, .alloc_err
    );

    always #(P/2) clk = ~clk;

    task automatic check(input string tag, input int got, input int exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %0d expected %0d", tag, got, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    task automatic do_reset(input logic [1:0] pol, input logic [6:0] pct, input logic [3:0] m);
        @(negedge clk);
        rst = 1'b1; share_pol = pol; cap_pct = pct; act_mask = m;
        alloc_req = '0; release_req = '0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic step(input logic [3:0] a, input logic [3:0] r, output logic [3:0] e);
        @(negedge clk);
        alloc_req = a; release_req = r;
        #(P/4);
        e = alloc_err;
        @(posedge clk);
        #1;
        alloc_req = '0; release_req = '0;
    endtask

    task automatic set_mask(input logic [3:0] m);
        @(negedge clk);
        act_mask = m;
        @(posedge clk);
        #1;
    endtask

    initial begin
        #(P * 100000);
        checks++;
        errors++;
        $display("FAIL watchdog: got 0 expected 1 (run did not end)");
        finish_run();
    end

    initial begin
        logic [3:0] e;

        // Reset state, shared policy
        do_reset(2'd0, 7'd0, 4'b1111);
        check("R1 reset glob_free", int'(glob_free), 16);
        check("R1 reset thr_free0", int'(thr_free[0]), 16);
        check("R8 reset glob_full", int'(glob_full), 0);

        // Vector walk: R6 R7 R8 R9 R10 R11
        for (int i = 0; i < 12; i++) begin
            step(VECS[i].alloc, VECS[i].rel, e);
            check($sformatf("R7_R8 vec%0d alloc_err", i), int'(e), int'(VECS[i].err));
            check($sformatf("R6_R11 vec%0d glob_free", i), int'(glob_free), int'(VECS[i].gfree));
            check($sformatf("R5 vec%0d thr_free0", i), int'(thr_free[0]), int'(VECS[i].t0free));
            check($sformatf("R8 vec%0d glob_full", i), int'(glob_full), int'(VECS[i].gfree == 0));
        end

        // R2: shared limits do not move on a mask change
        set_mask(4'b0001);
        check("R2 shared thr_free3 after mask change", int'(thr_free[3]), 16 - 4);

        // R1: code 3 behaves as shared
        do_reset(2'd3, 7'd50, 4'b1111);
        check("R1 code3 thr_free0", int'(thr_free[0]), 16);
        check("R1 reset clears glob_free", int'(glob_free), 16);

        // Equal split: 16/4 = 4
        do_reset(2'd1, 7'd0, 4'b1111);
        check("R1 split thr_free0", int'(thr_free[0]), 4);
        for (int k = 0; k < 4; k++) step(4'b0001, 4'b0000, e);
        check("R5 thread0 full", int'(thr_full[0]), 1);
        check("R6 glob_free after 4", int'(glob_free), 12);
        step(4'b0001, 4'b0000, e);
        check("R7 reject err", int'(e), 1);
        check("R7 reject no count change", int'(glob_free), 12);
        step(4'b0001, 4'b0001, e);
        check("R9 cancel while full err", int'(e), 0);
        check("R9 cancel glob_free", int'(glob_free), 12);

        // R3: two active threads -> 8; inactive keep 4
        set_mask(4'b0011);
        check("R3 split2 thr_free0", int'(thr_free[0]), 4);
        check("R3 inactive thr_free2", int'(thr_free[2]), 4);
        // R3: three active -> 5
        set_mask(4'b0111);
        check("R3 split3 thr_free0", int'(thr_free[0]), 1);
        check("R3 inactive thr_free3", int'(thr_free[3]), 4);
        step(4'b0001, 4'b0000, e);
        check("R6 thread0 to 5", int'(glob_free), 11);
        // Shrink below occupancy: limit 4, occupancy 5
        set_mask(4'b1111);
        check("R5 clamp thr_free0", int'(thr_free[0]), 0);
        check("R5 clamp full0", int'(thr_full[0]), 1);
        step(4'b0000, 4'b0001, e);
        check("R5 still full at occ4", int'(thr_free[0]), 0);
        step(4'b0000, 4'b0001, e);
        check("R5 drain thr_free0", int'(thr_free[0]), 1);
        check("R11 drain glob_free", int'(glob_free), 13);

        // R1: policy inputs ignored after reset
        do_reset(2'd1, 7'd0, 4'b1111);
        @(negedge clk) share_pol = 2'd0;
        set_mask(4'b0011);
        check("R1 policy captured at reset", int'(thr_free[0]), 8);

        // Percentage cap: 30% of 16 = 4
        do_reset(2'd2, 7'd30, 4'b1111);
        check("R1 pct thr_free0", int'(thr_free[0]), 4);
        set_mask(4'b0100);
        check("R4 single active thr_free2", int'(thr_free[2]), 16);
        check("R4 others kept thr_free0", int'(thr_free[0]), 4);
        set_mask(4'b0110);
        check("R4 multi no change thr_free1", int'(thr_free[1]), 4);
        check("R4 multi no change thr_free2", int'(thr_free[2]), 16);

        // R1: percentage above 100 clamps
        do_reset(2'd2, 7'd120, 4'b1111);
        check("R1 pct clamp thr_free3", int'(thr_free[3]), 16);

        finish_run();
    end

endmodule